// File: doc/BRIEF.md
# CAN Dominant-Timeout Guard and Bus-Silence Monitor

This block sits between a CAN protocol engine and its line driver. It passes the engine's transmit bit to the driver through one register stage and counts how many clocks in a row that bit has been dominant (low). If the count passes a parameter limit, the driver output is forced recessive (high) and a fault flag is raised. The forced state lasts until the engine's transmit bit is sampled recessive again. This stops a stuck transmitter from holding the whole bus dominant.

Alongside the guard, the received bus bit goes through a synchroniser and an edge detector. Every transition, in either direction, restarts an inactivity timer. When the timer reaches its limit with no transition, a silence flag is raised. Both limits are given in clock cycles. With a 40 MHz clock, the defaults give 3 ms for the dominant limit and 0.9 s for the inactivity limit. To keep a legal frame from tripping the guard, the dominant limit must exceed eleven bit times at the slowest bit rate in use.

Top module: `can_tx_guard`

## Requirements
- R1: While no fault is active, `txd_out` equals the value `txd_in` had at the previous rising clock edge (one register of latency); 0 is dominant and 1 is recessive.
- R2: If `txd_in` is sampled low on DOM_LIMIT consecutive edges, the guard does not trip. If it is sampled low on a further consecutive edge (edge DOM_LIMIT+1), `drv_fault` becomes 1 and `txd_out` becomes 1 at that edge.
- R3: While `txd_in` stays low after a trip, `drv_fault` stays 1 and `txd_out` stays 1, however long the low lasts. The run-length counter saturates and never wraps.
- R4: At the first edge that samples `txd_in` high after a trip, `drv_fault` clears and `txd_out` is 1 in the same cycle. A later low run is counted from zero.
- R5: A single high sample between two low runs restarts the count, so a train of low runs, each no longer than DOM_LIMIT, never trips the guard.
- R6: With `rxd_in` unchanged, `bus_silent` becomes 1 at the SIL_LIMIT-th edge after the last detected transition and stays 1. After reset with `rxd_in` high, it rises at the SIL_LIMIT-th edge after reset is released.
- R7: A transition of `rxd_in` in either direction is detected SYNC_STAGES+1 edges after it is applied. At that edge `bus_silent` clears and the inactivity timer restarts from zero.
- R8: A synchronous active-high `rst` sets `txd_out` to 1, clears `drv_fault` and `bus_silent`, and loads the synchroniser with the recessive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txd_in | input | 1 | Transmit bit from the protocol engine (0 dominant) |
| rxd_in | input | 1 | Received bus bit, asynchronous to clk |
| txd_out | output | 1 | Gated transmit bit to the line driver |
| drv_fault | output | 1 | Dominant-timeout lockout active |
| bus_silent | output | 1 | No bus transition within the inactivity limit |

## Verification
The bench sweeps the length of the dominant run from one cycle to several cycles past the limit. A guard that trips one cycle early or one cycle late, or that lets the driver go dominant on the trip cycle, shows up at the boundary width. A run held for several multiples of the limit catches a counter that wraps and silently re-enables the driver. A train of maximal runs with one-cycle recessive gaps catches a counter that does not clear. The bench also sweeps the gap between received transitions around the silence limit, in both directions. A wrong synchroniser depth, a detector that only sees one polarity, or a timer that is not restarted would move or miss the flag edge.

// File: rtl/can_guard_pkg.sv
package can_guard_pkg;
  // Line levels as seen on the logic side of a CAN transceiver
  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;

  // Counter width able to hold the value lim
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/dom_timeout_guard.sv
module dom_timeout_guard
  import can_guard_pkg::*;
#(
  parameter int unsigned DOM_LIMIT = 120_000
) (
  input  logic clk,
  input  logic rst,
  input  logic txd_in,
  output logic txd_out,
  output logic fault
);
  localparam int unsigned CW = cnt_width(DOM_LIMIT);
  localparam logic [CW-1:0] LIM = CW'(DOM_LIMIT);

  logic [CW-1:0] run_q, run_d;
  logic          fault_q, fault_d;
  logic          out_q;
  logic          at_lim;

  assign at_lim = (run_q == LIM);

  // Run length of dominant samples, saturating at the limit
  always_comb begin
    if (txd_in == LVL_REC)
      run_d = '0;
    else if (at_lim)
      run_d = LIM;
    else
      run_d = run_q + CW'(1);
  end

  // Lockout: entered when a dominant sample arrives with the run already
  // at the limit, kept while dominant persists, dropped on recessive
  assign fault_d = (txd_in == LVL_DOM) && (fault_q || at_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      fault_q <= 1'b0;
      out_q   <= LVL_REC;
    end else begin
      run_q   <= run_d;
      fault_q <= fault_d;
      out_q   <= txd_in | fault_d;
    end
  end

  assign txd_out = out_q;
  assign fault   = fault_q;
endmodule

// File: rtl/bus_edge_sync.sv
module bus_edge_sync
  import can_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd_in,
  output logic edge_seen
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= LVL_REC;
    else     chain_q[0] <= rxd_in;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[g] <= LVL_REC;
      else     chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= LVL_REC;
    else     last_q <= chain_q[SYNC_STAGES-1];
  end

  // Either polarity of change counts as bus activity
  assign edge_seen = chain_q[SYNC_STAGES-1] ^ last_q;
endmodule

// File: rtl/silence_timer.sv
module silence_timer
  import can_guard_pkg::*;
#(
  parameter int unsigned SIL_LIMIT = 36_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic activity,
  output logic silent
);
  localparam int unsigned CW = cnt_width(SIL_LIMIT);
  localparam logic [CW-1:0] LIM  = CW'(SIL_LIMIT);
  localparam logic [CW-1:0] LIM1 = CW'(SIL_LIMIT - 1);

  logic [CW-1:0] idle_q;
  logic          silent_q;

  always_ff @(posedge clk) begin
    if (rst || activity) begin
      idle_q   <= '0;
      silent_q <= 1'b0;
    end else begin
      if (idle_q != LIM) idle_q <= idle_q + CW'(1);
      silent_q <= silent_q || (idle_q == LIM1);
    end
  end

  assign silent = silent_q;
endmodule

// File: rtl/can_tx_guard.sv
module can_tx_guard #(
  parameter int unsigned DOM_LIMIT   = 120_000,
  parameter int unsigned SIL_LIMIT   = 36_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic txd_in,
  input  logic rxd_in,
  output logic txd_out,
  output logic drv_fault,
  output logic bus_silent
);
  logic bus_edge;

  dom_timeout_guard #(.DOM_LIMIT(DOM_LIMIT)) u_guard (
    .clk     (clk),
    .rst     (rst),
    .txd_in  (txd_in),
    .txd_out (txd_out),
    .fault   (drv_fault)
  );

  bus_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .rxd_in    (rxd_in),
    .edge_seen (bus_edge)
  );

  silence_timer #(.SIL_LIMIT(SIL_LIMIT)) u_sil (
    .clk      (clk),
    .rst      (rst),
    .activity (bus_edge),
    .silent   (bus_silent)
  );
endmodule

// File: rtl/can_tx_guard_chk.sv
module can_tx_guard_chk (
  input logic clk,
  input logic rst,
  input logic txd_in,
  input logic txd_out,
  input logic drv_fault,
  input logic bus_silent,
  input logic bus_edge
);
  // R1 / R2: during lockout the driver never sees dominant
  a_r2_forced_recessive: assert property (@(posedge clk) disable iff (rst)
    drv_fault |-> txd_out);

  // R1: without a fault the output follows the previous input sample
  a_r1_follow: assert property (@(posedge clk) disable iff (rst)
    (!drv_fault && !$past(rst)) |-> (txd_out == $past(txd_in)));

  // R3: lockout persists while the input stays dominant
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (drv_fault && !txd_in) |=> drv_fault);

  // R4: a recessive input sample releases the lockout at once
  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    (drv_fault && txd_in) |=> (!drv_fault && txd_out));

  // R7: detected activity clears the silence flag
  a_r7_edge_clears: assert property (@(posedge clk) disable iff (rst)
    bus_edge |=> !bus_silent);

  // R6: the silence flag is held until activity
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (bus_silent && !bus_edge) |=> bus_silent);
endmodule

bind can_tx_guard can_tx_guard_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .txd_in     (txd_in),
  .txd_out    (txd_out),
  .drv_fault  (drv_fault),
  .bus_silent (bus_silent),
  .bus_edge   (bus_edge)
);

// File: tb/can_tx_guard_tb_top.sv
`timescale 1ns/1ps
module can_tx_guard_tb_top;
  localparam int DL = 6;
  localparam int SL = 10;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txd_in = 1'b1;
  logic rxd_in = 1'b1;
  logic txd_out, drv_fault, bus_silent;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_tx_guard #(.DOM_LIMIT(DL), .SIL_LIMIT(SL), .SYNC_STAGES(SS)) dut_i (
    .clk(clk), .rst(rst), .txd_in(txd_in), .rxd_in(rxd_in),
    .txd_out(txd_out), .drv_fault(drv_fault), .bus_silent(bus_silent)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; txd_in = 1'b1; rxd_in = 1'b1;
    repeat (3) tick();
    chk("R8", "txd_out", txd_out, 1'b1);
    chk("R8", "drv_fault", drv_fault, 1'b0);
    chk("R8", "bus_silent", bus_silent, 1'b0);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    do_reset();

    // R6: silence rises SL edges after reset release with idle bus
    for (int n = 1; n <= SL + 3; n++) begin
      tick();
      chk("R6", "bus_silent after reset", bus_silent, logic'(n >= SL));
    end

    // R1: plain pass-through pattern, one cycle latency
    for (int i = 0; i < 12; i++) begin
      txd_in = logic'((i % 3) != 0);
      tick();
      chk("R1", "txd_out follows", txd_out, logic'((i % 3) != 0));
      chk("R1", "no fault", drv_fault, 1'b0);
    end
    txd_in = 1'b1; tick();

    // R2 / R4: sweep dominant run width around the limit
    for (int w = 1; w <= DL + 4; w++) begin
      txd_in = 1'b0;
      for (int n = 1; n <= w; n++) begin
        tick();
        chk("R2", "txd_out in run", txd_out, logic'(n > DL));
        chk("R2", "fault in run", drv_fault, logic'(n > DL));
      end
      txd_in = 1'b1;
      tick();
      chk("R4", "release txd_out", txd_out, 1'b1);
      chk("R4", "release fault", drv_fault, 1'b0);
      tick();
    end

    // R3: long lockout, several multiples of the limit (no wrap)
    txd_in = 1'b0;
    for (int n = 1; n <= 5 * DL + 3; n++) begin
      tick();
      chk("R3", "lockout fault", drv_fault, logic'(n > DL));
      chk("R3", "lockout txd_out", txd_out, logic'(n > DL));
    end
    // R4: release then a fresh run counts from zero
    txd_in = 1'b1; tick();
    chk("R4", "release fault", drv_fault, 1'b0);
    txd_in = 1'b0;
    for (int n = 1; n <= DL + 1; n++) begin
      tick();
      chk("R4", "fresh run fault", drv_fault, logic'(n > DL));
    end
    txd_in = 1'b1; tick();

    // R5: train of maximal runs with one-cycle recessive gaps
    for (int r = 0; r < 5; r++) begin
      txd_in = 1'b0;
      for (int n = 1; n <= DL; n++) begin
        tick();
        chk("R5", "train fault", drv_fault, 1'b0);
        chk("R5", "train txd_out", txd_out, 1'b0);
      end
      txd_in = 1'b1;
      tick();
      chk("R5", "gap txd_out", txd_out, 1'b1);
    end

    // R8: reset in the middle of a lockout
    txd_in = 1'b0;
    repeat (DL + 2) tick();
    chk("R3", "tripped before reset", drv_fault, 1'b1);
    do_reset();

    // R7 / R6: sweep the gap between bus transitions, both polarities
    for (int g = 1; g <= SL + 3; g++) begin
      rxd_in = ~rxd_in;
      for (int n = 1; n <= SS + 1 + g; n++) begin
        tick();
        if (n == SS + 1)
          chk("R7", "edge clears silent", bus_silent, 1'b0);
        else if (n > SS + 1)
          chk("R6", "silent after gap", bus_silent, logic'((n - SS - 1) >= SL));
      end
    end

    // R7: flag raised, then a single transition clears it at the right edge
    repeat (SL + 2) tick();
    chk("R6", "silent raised", bus_silent, 1'b1);
    rxd_in = ~rxd_in;
    for (int n = 1; n <= SS + 1; n++) begin
      tick();
      chk("R7", "clear latency", bus_silent, logic'(n < SS + 1));
    end

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule